// File: doc/BRIEF.md
# AUX Request Header Formatter

This block turns one display auxiliary-channel request into a byte stream and then interprets the sink's answer. A requester presents a 20-bit target address, a 4-bit request code, a payload length and, for writes, up to sixteen payload bytes. The block checks the request first. It then emits a four-byte header, followed by the write payload when there is one, on a valid/ready byte stream. After the last byte it listens for the reply: one status byte and then any data bytes, with the last byte flagged.

When the reply ends, or at once for a rejected request, the block raises a one-cycle result strobe. The strobe comes with a result kind, the reply nibble, a byte count and the received read data. The fourth header byte holds two fields. The low nibble is the payload length minus one. The high nibble is a transmit-size value, and it takes a fixed bare-address value when the length is zero. Only one request is handled at a time.

Top module: `aux_req_fmt`

## Requirements
- R1: Header byte 0 is address bits 7:0 and header byte 1 is address bits 15:8. Header byte 2 carries the request code in bits 7:4 and address bits 19:16 in bits 3:0.
- R2: Bits 3:0 of header byte 3 hold the payload length minus one, or 0 when the length is 0.
- R3: Bits 7:4 of header byte 3 hold 3 for a zero-length request of either direction. For a write with nonzero length they hold the low four bits of 4 plus the length. For a read with nonzero length they hold 4.
- R4: A write sends the four header bytes and then its payload bytes, payload byte k taken from req_data[8k+7:8k]. A read sends only the four header bytes. While tx_valid is high and tx_ready is low, the offered byte does not change.
- R5: A length above 16 ends the request with result kind 1 (too big), count 0, reply 0, and no byte sent.
- R6: Bit 2 of the code (the middle-of-transaction flag) is cleared before the code is checked. The cleared code must be 0 or 8 (write) or 1 or 9 (read). Any other code ends with result kind 2 (bad request), count 0 and no byte sent.
- R7: A status byte equal to 1, 2 or 3 gives result kind 3 (timeout), 4 (flags not zero) or 5 (general error). Each of these reports count 0, reply 0 and all-zero data.
- R8: Any other status byte gives result kind 0 (success), with res_reply equal to status bits 7:4.
- R9: A successful read reports the number of data bytes received, clipped to the requested length. Data byte k sits in res_data[8k+7:8k], and bytes beyond the requested length are dropped.
- R10: A successful write reports its payload length as the count and all-zero data.
- R11: busy goes high on the cycle after a request is accepted and stays high through the one-cycle res_valid strobe. req_ready is low while busy is high, and busy is low again on the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; a request is taken this cycle |
| req_addr | input | 20 | Target address |
| req_code | input | 4 | Request code |
| req_len | input | 8 | Payload length in bytes |
| req_data | input | 128 | Write payload, byte k at bits 8k+7:8k |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Downstream takes the byte |
| tx_byte | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Reply byte valid |
| rx_byte | input | 8 | Reply byte, status first |
| rx_last | input | 1 | Marks the final reply byte |
| busy | output | 1 | A request is in flight |
| res_valid | output | 1 | One-cycle result strobe |
| res_kind | output | 3 | Result kind (0 ok, 1 too big, 2 bad request, 3 timeout, 4 flags, 5 error) |
| res_reply | output | 4 | Reply nibble on success |
| res_count | output | 5 | Byte count result |
| res_data | output | 128 | Received read data |

## Verification
The bench targets the packed length byte at its edges: zero length in both directions, and a sixteen-byte write, where 4 plus 16 wraps the high nibble to 4. A formatter that used the header size for writes, or failed to force 3 for bare-address requests, would put the wrong value in byte 3. Reads that return more bytes than requested check the clipping: an unclipped design reports too large a count and stores bytes that do not belong. Stalls on tx_ready, lengths just above the limit, and codes that are legal only once the flag bit is cleared catch a block that drops or repeats bytes, sends before rejecting, or rejects valid I2C and native requests. Statuses 1, 2 and 3, and a status with a nonzero high nibble, check that errors carry no count and that the reply nibble comes from the upper bits.

// File: rtl/aux_req_pkg.sv
// Package: shared constants and enumerations for the AUX request formatter.
// Assumes the four-byte header layout and the result-kind coding in the brief.
package aux_req_pkg;
    localparam int HDR_BYTES  = 4;
    localparam int BARE_SIZE  = 3;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_TOOBIG  = 3'd1,
        RES_BADREQ  = 3'd2,
        RES_TIMEOUT = 3'd3,
        RES_FLAGS   = 3'd4,
        RES_FAULT   = 3'd5
    } res_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_RECV = 2'd2,
        ST_DONE = 2'd3
    } fmt_state_t;
endpackage

// File: rtl/aux_hdr_pack.sv
// Module: aux_hdr_pack
// Purely combinational packing of the four header bytes from a held request.
// Assumes ADDR_W <= 24. Byte 3 packs the length-minus-one nibble with the
// transmit-size nibble; the size is truncated to four bits, as the field is.
module aux_hdr_pack #(
    parameter int ADDR_W = 20,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        code,
    input  logic [LEN_W-1:0]  len,
    input  logic              is_write,
    output logic [31:0]       hdr
);
    import aux_req_pkg::*;

    logic [23:0]     addr_ext;
    logic [LEN_W:0]  tx_total;
    logic [3:0]      len_nib;
    logic [3:0]      size_nib;

    // Form both nibbles of the length byte and lay out the header.
    always_comb begin
        addr_ext = 24'(addr);
        tx_total = (LEN_W+1)'(HDR_BYTES) + (LEN_W+1)'(len);
        if (len == '0) begin
            len_nib  = 4'd0;
            size_nib = 4'(BARE_SIZE);
        end else begin
            len_nib  = 4'(len - LEN_W'(1));
            size_nib = is_write ? tx_total[3:0] : 4'(HDR_BYTES);
        end
        hdr[7:0]   = addr_ext[7:0];
        hdr[15:8]  = addr_ext[15:8];
        hdr[23:16] = {code, addr_ext[19:16]};
        hdr[31:24] = {size_nib, len_nib};
    end
endmodule

// File: rtl/aux_tx_seq.sv
// Module: aux_tx_seq
// Streams nbytes bytes: header bytes first, then payload bytes, over a
// valid/ready handshake. start loads a new run and must only come while idle.
// done pulses in the cycle in which the final byte is taken.
module aux_tx_seq #(
    parameter int MAX_LEN = 16,
    parameter int IDX_W   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [IDX_W-1:0]     nbytes,
    input  logic [31:0]          hdr,
    input  logic [MAX_LEN*8-1:0] pay,
    input  logic                 tx_ready,
    output logic                 tx_valid,
    output logic [7:0]           tx_byte,
    output logic                 done
);
    import aux_req_pkg::*;

    logic             active;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] pay_idx;

    // Track the byte position of the run and end it after the final byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            idx      <= '0;
            last_idx <= '0;
        end else if (start) begin
            active   <= 1'b1;
            idx      <= '0;
            last_idx <= nbytes - IDX_W'(1);
        end else if (active && tx_ready) begin
            if (idx == last_idx) active <= 1'b0;
            else                 idx    <= idx + IDX_W'(1);
        end
    end

    // Pick the byte for the current position from the header or the payload.
    always_comb begin
        pay_idx = idx - IDX_W'(HDR_BYTES);
        tx_byte = 8'h00;
        if (idx < IDX_W'(HDR_BYTES)) begin
            for (int h = 0; h < HDR_BYTES; h++)
                if (idx == IDX_W'(h)) tx_byte = hdr[h*8 +: 8];
        end else begin
            for (int k = 0; k < MAX_LEN; k++)
                if (pay_idx == IDX_W'(k)) tx_byte = pay[k*8 +: 8];
        end
    end

    assign tx_valid = active;
    assign done     = active && tx_ready && (idx == last_idx);
endmodule

// File: rtl/aux_reply_dec.sv
// Module: aux_reply_dec
// Captures the reply: the first byte taken after clear is the status, and
// read data follow, clipped to the requested length. Result fields are
// decoded from the held state; done pulses when the final byte is taken.
module aux_reply_dec #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 8,
    parameter int CNT_W   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 enable,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_byte,
    input  logic                 rx_last,
    input  logic [LEN_W-1:0]     want,
    input  logic                 is_write,
    output logic                 done,
    output logic [2:0]           kind,
    output logic [3:0]           reply,
    output logic [CNT_W-1:0]     count,
    output logic [MAX_LEN*8-1:0] data
);
    import aux_req_pkg::*;

    logic                 have_status;
    logic [7:0]           status;
    logic [CNT_W-1:0]     cnt;
    logic [MAX_LEN*8-1:0] buf_q;
    logic                 ok;

    // Hold the status byte and store read bytes up to the requested length.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            have_status <= 1'b0;
            status      <= 8'h00;
            cnt         <= '0;
            buf_q       <= '0;
        end else if (enable && rx_valid) begin
            if (!have_status) begin
                have_status <= 1'b1;
                status      <= rx_byte;
            end else if (!is_write && (LEN_W'(cnt) < want)) begin
                for (int k = 0; k < MAX_LEN; k++)
                    if (cnt == CNT_W'(k)) buf_q[k*8 +: 8] <= rx_byte;
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // Map the status byte to a result kind and mask the fields on error.
    always_comb begin
        case (status)
            8'd1:    kind = RES_TIMEOUT;
            8'd2:    kind = RES_FLAGS;
            8'd3:    kind = RES_FAULT;
            default: kind = RES_OK;
        endcase
        ok    = (kind == RES_OK);
        reply = ok ? status[7:4] : 4'h0;
        count = !ok ? '0 : (is_write ? CNT_W'(want) : cnt);
        data  = ok ? buf_q : '0;
    end

    assign done = enable && rx_valid && rx_last;
endmodule

// File: rtl/aux_req_fmt.sv
// Module: aux_req_fmt (top)
// Takes one AUX request, checks it, streams the header and the write payload,
// then decodes the reply and strobes a result. Only one request is in flight.
// Assumes reply bytes arrive only after the final transmit byte; bytes seen
// at any other time are ignored.
module aux_req_fmt #(
    parameter int ADDR_W  = 20,
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [3:0]           req_code,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [MAX_LEN*8-1:0] req_data,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic [7:0]           tx_byte,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_byte,
    input  logic                 rx_last,
    output logic                 busy,
    output logic                 res_valid,
    output logic [2:0]           res_kind,
    output logic [3:0]           res_reply,
    output logic [$clog2(MAX_LEN+1)-1:0] res_count,
    output logic [MAX_LEN*8-1:0] res_data
);
    import aux_req_pkg::*;

    localparam int IDX_W = $clog2(MAX_LEN + HDR_BYTES + 1);
    localparam int CNT_W = $clog2(MAX_LEN + 1);
    localparam int PAY_W = MAX_LEN * 8;

    fmt_state_t        st;
    logic [ADDR_W-1:0] a_addr;
    logic [3:0]        a_code;
    logic [LEN_W-1:0]  a_len;
    logic [PAY_W-1:0]  a_pay;
    logic              a_write;
    logic              rejected;
    logic [2:0]        rej_kind;

    logic              accept, too_big, legal, req_wr, launch;
    logic [3:0]        base_code;
    logic [IDX_W-1:0]  n_send;
    logic [31:0]       hdr;
    logic              tx_done, rx_done;
    logic [2:0]        dec_kind;
    logic [3:0]        dec_reply;
    logic [CNT_W-1:0]  dec_count;
    logic [PAY_W-1:0]  dec_data;

    // Check the offered request and size the byte run it needs.
    always_comb begin
        accept    = req_valid && (st == ST_IDLE);
        base_code = req_code & 4'b1011;
        too_big   = req_len > LEN_W'(MAX_LEN);
        legal     = (base_code == 4'h0) || (base_code == 4'h1) ||
                    (base_code == 4'h8) || (base_code == 4'h9);
        req_wr    = ~req_code[0];
        launch    = accept && !too_big && legal;
        n_send    = IDX_W'(HDR_BYTES) + (req_wr ? IDX_W'(req_len) : IDX_W'(0));
    end

    // Sequence the request through send, receive and result phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            a_addr   <= '0;
            a_code   <= '0;
            a_len    <= '0;
            a_pay    <= '0;
            a_write  <= 1'b0;
            rejected <= 1'b0;
            rej_kind <= RES_OK;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    a_addr  <= req_addr;
                    a_code  <= req_code;
                    a_len   <= req_len;
                    a_pay   <= req_data;
                    a_write <= req_wr;
                    if (too_big) begin
                        rejected <= 1'b1;
                        rej_kind <= RES_TOOBIG;
                        st       <= ST_DONE;
                    end else if (!legal) begin
                        rejected <= 1'b1;
                        rej_kind <= RES_BADREQ;
                        st       <= ST_DONE;
                    end else begin
                        rejected <= 1'b0;
                        rej_kind <= RES_OK;
                        st       <= ST_SEND;
                    end
                end
                ST_SEND: if (tx_done) st <= ST_RECV;
                ST_RECV: if (rx_done) st <= ST_DONE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    aux_hdr_pack #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_hdr (
        .addr     (a_addr),
        .code     (a_code),
        .len      (a_len),
        .is_write (a_write),
        .hdr      (hdr)
    );

    aux_tx_seq #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (launch),
        .nbytes   (n_send),
        .hdr      (hdr),
        .pay      (a_pay),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte),
        .done     (tx_done)
    );

    aux_reply_dec #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .enable   (st == ST_RECV),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rx_last  (rx_last),
        .want     (a_len),
        .is_write (a_write),
        .done     (rx_done),
        .kind     (dec_kind),
        .reply    (dec_reply),
        .count    (dec_count),
        .data     (dec_data)
    );

    // Drive the handshake flags and select rejection or decoded results.
    always_comb begin
        req_ready = (st == ST_IDLE);
        busy      = (st != ST_IDLE);
        res_valid = (st == ST_DONE);
        res_kind  = rejected ? rej_kind : dec_kind;
        res_reply = rejected ? 4'h0     : dec_reply;
        res_count = rejected ? '0       : dec_count;
        res_data  = rejected ? '0       : dec_data;
    end
endmodule

// File: rtl/aux_req_fmt_chk.sv
// Module: aux_req_fmt_chk
// Port-level checker bound to aux_req_fmt: handshake stability, busy
// framing around a request, and the shape of reported results.
module aux_req_fmt_chk #(
    parameter int MAX_LEN = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 busy,
    input logic                 tx_valid,
    input logic                 tx_ready,
    input logic [7:0]           tx_byte,
    input logic                 res_valid,
    input logic [2:0]           res_kind,
    input logic [3:0]           res_reply,
    input logic [$clog2(MAX_LEN+1)-1:0] res_count,
    input logic [MAX_LEN*8-1:0] res_data
);
    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    // R11
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R11
    res_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy);

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R4
    tx_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    // R7
    err_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind >= 3'd3) |-> (res_count == '0 && res_reply == 4'h0 && res_data == '0));

    // R5
    reject_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_kind == 3'd1 || res_kind == 3'd2)) |-> (res_count == '0 && res_reply == 4'h0));

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_count <= ($clog2(MAX_LEN+1))'(MAX_LEN)));
endmodule

bind aux_req_fmt aux_req_fmt_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_byte   (tx_byte),
    .res_valid (res_valid),
    .res_kind  (res_kind),
    .res_reply (res_reply),
    .res_count (res_count),
    .res_data  (res_data)
);

// File: tb/sim_aux_req_fmt.sv
// Scoreboard bench: the driver task queues expected bytes and results,
// and the monitor pops and compares them as the design produces them.
module sim_aux_req_fmt;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         req_valid = 0;
    logic         req_ready;
    logic [19:0]  req_addr = 0;
    logic [3:0]   req_code = 0;
    logic [7:0]   req_len = 0;
    logic [127:0] req_data = 0;
    logic         tx_valid;
    logic         tx_ready = 0;
    logic [7:0]   tx_byte;
    logic         rx_valid = 0;
    logic [7:0]   rx_byte = 0;
    logic         rx_last = 0;
    logic         busy;
    logic         res_valid;
    logic [2:0]   res_kind;
    logic [3:0]   res_reply;
    logic [4:0]   res_count;
    logic [127:0] res_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]   txq[$];
    string        txtag[$];
    logic [2:0]   ek_q[$];
    logic [3:0]   er_q[$];
    logic [4:0]   ec_q[$];
    logic [127:0] ed_q[$];
    string        etag[$];

    always #2 clk = ~clk;

    aux_req_fmt u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_code(req_code), .req_len(req_len), .req_data(req_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last),
        .busy(busy), .res_valid(res_valid), .res_kind(res_kind), .res_reply(res_reply),
        .res_count(res_count), .res_data(res_data)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // stall pattern on tx_ready, changed just after each rising edge
    initial begin
        int c = 0;
        forever begin
            @(posedge clk);
            #1;
            c++;
            tx_ready = (c % 3) != 0;
        end
    end

    // monitor: compare every taken byte and every result strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                if (txq.size() == 0) begin
                    check(0, "R4,R5,R6 unexpected byte", {120'h0, tx_byte}, 128'h0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = txq.pop_front();
                    t = txtag.pop_front();
                    check(tx_byte == e, t, {120'h0, tx_byte}, {120'h0, e});
                end
            end
            if (res_valid) begin
                if (ek_q.size() == 0) begin
                    check(0, "R11 unexpected result", {125'h0, res_kind}, 128'h0);
                end else begin
                    logic [2:0] k; logic [3:0] r; logic [4:0] c; logic [127:0] d; string t;
                    k = ek_q.pop_front(); r = er_q.pop_front(); c = ec_q.pop_front();
                    d = ed_q.pop_front(); t = etag.pop_front();
                    check(res_kind == k, {t, " kind"}, {125'h0, res_kind}, {125'h0, k});
                    check(res_reply == r, {t, " reply"}, {124'h0, res_reply}, {124'h0, r});
                    check(res_count == c, {t, " count"}, {123'h0, res_count}, {123'h0, c});
                    check(res_data == d, {t, " data"}, res_data, d);
                end
            end
        end
    end

    // driver: queue expectations from the requirements, then run one request
    task automatic txn(input logic [19:0] addr, input logic [3:0] code, input logic [7:0] len,
                       input logic [127:0] pay, input logic [7:0] status, input int nrx,
                       input logic [127:0] rxd, input string tag);
        logic [3:0] base;
        bit wr, sends;
        logic [7:0] lo, hi;
        logic [2:0] ek; logic [3:0] er; logic [4:0] ec; logic [127:0] ed;
        base  = code & 4'b1011;
        wr    = (code[0] == 1'b0);
        sends = 0; er = 0; ec = 0; ed = 0;
        if (len > 16) ek = 3'd1;
        else if (!(base == 0 || base == 1 || base == 8 || base == 9)) ek = 3'd2;
        else begin
            sends = 1;
            lo = (len == 0) ? 8'd0 : ((len - 1) & 8'h0F);
            hi = (len == 0) ? 8'd3 : (wr ? ((8'd4 + len) & 8'h0F) : 8'd4);
            txq.push_back(addr[7:0]);          txtag.push_back({tag, " R1 byte0"});
            txq.push_back(addr[15:8]);         txtag.push_back({tag, " R1 byte1"});
            txq.push_back({code, addr[19:16]});txtag.push_back({tag, " R1 byte2"});
            txq.push_back({hi[3:0], lo[3:0]}); txtag.push_back({tag, " R2,R3 byte3"});
            if (wr) for (int k = 0; k < len; k++) begin
                txq.push_back(pay[k*8 +: 8]);  txtag.push_back({tag, " R4 payload"});
            end
            if (status == 1) ek = 3'd3;
            else if (status == 2) ek = 3'd4;
            else if (status == 3) ek = 3'd5;
            else begin
                ek = 3'd0;
                er = status[7:4];
                if (wr) ec = len[4:0];
                else begin
                    int n;
                    n = (nrx < len) ? nrx : len;
                    ec = n[4:0];
                    for (int k = 0; k < n; k++) ed[k*8 +: 8] = rxd[k*8 +: 8];
                end
            end
        end
        ek_q.push_back(ek); er_q.push_back(er); ec_q.push_back(ec); ed_q.push_back(ed);
        etag.push_back(tag);

        @(posedge clk); #1;
        req_valid = 1; req_addr = addr; req_code = code; req_len = len; req_data = pay;
        @(posedge clk); #1;
        req_valid = 0;
        @(negedge clk);
        // R11: busy and not ready once the request is taken
        check(busy == 1'b1 && req_ready == 1'b0, {tag, " R11 busy after accept"},
              {126'h0, busy, req_ready}, 128'h2);
        if (sends) begin
            while (txq.size() != 0) @(negedge clk);
            for (int i = 0; i <= nrx; i++) begin
                @(posedge clk); #1;
                rx_valid = 1;
                rx_byte  = (i == 0) ? status : rxd[(i-1)*8 +: 8];
                rx_last  = (i == nrx);
            end
            @(posedge clk); #1;
            rx_valid = 0; rx_last = 0;
        end
        while (ek_q.size() != 0) @(negedge clk);
        @(negedge clk);
        // R11: idle again after the result strobe
        check(busy == 1'b0 && req_ready == 1'b1, {tag, " R11 idle after result"},
              {126'h0, busy, req_ready}, 128'h1);
        // R5 R6: rejected requests left no byte behind
        check(txq.size() == 0, {tag, " R4,R5 byte queue drained"}, txq.size(), 0);
    endtask

    initial begin
        #(4 * 150000);
        check(0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        logic [127:0] p;
        logic [127:0] d;
        for (int k = 0; k < 16; k++) begin
            p[k*8 +: 8] = 8'hA0 + 8'(k);
            d[k*8 +: 8] = 8'h30 + 8'(k * 7);
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(busy == 0 && req_ready == 1 && tx_valid == 0 && res_valid == 0,
              "R11 reset state", {124'h0, busy, req_ready, tx_valid, res_valid}, 128'h4);

        txn(20'h5A3C1, 4'h8, 8'd3,  p, 8'h00, 0,  d, "R1,R4,R10 native write 3");
        txn(20'h00123, 4'h9, 8'd4,  p, 8'h20, 6,  d, "R8,R9 native read clip");
        txn(20'hF0F0F, 4'h1, 8'd0,  p, 8'h00, 0,  d, "R3,R9 bare read");
        txn(20'h80001, 4'h0, 8'd0,  p, 8'h00, 0,  d, "R3,R10 bare write");
        txn(20'h7FFFE, 4'h4, 8'd16, p, 8'h10, 0,  d, "R3,R4,R6 write 16 flag");
        txn(20'h11111, 4'h8, 8'd17, p, 8'h00, 0,  d, "R5 too long");
        txn(20'h22222, 4'h2, 8'd2,  p, 8'h00, 0,  d, "R6 bad code 2");
        txn(20'h33333, 4'hA, 8'd1,  p, 8'h00, 0,  d, "R6 bad code A");
        txn(20'h44444, 4'h9, 8'd2,  p, 8'h01, 2,  d, "R7 timeout");
        txn(20'h55555, 4'h9, 8'd2,  p, 8'h02, 2,  d, "R7 flags");
        txn(20'h66666, 4'h8, 8'd5,  p, 8'h03, 0,  d, "R7 fault");
        txn(20'h9ABCD, 4'hD, 8'd16, p, 8'h14, 5,  d, "R6,R8,R9 short read");
        txn(20'hC0DE5, 4'h9, 8'd12, p, 8'h80, 12, d, "R2,R8,R9 read 12");
        txn(20'h0000F, 4'hC, 8'd1,  p, 8'hF0, 0,  d, "R2,R6,R10 write 1 flag");

        repeat (4) @(posedge clk);
        summary();
        $finish;
    end
endmodule